// File: doc/BRIEF.md
# UART Receive Status and Request Logic

This block sits behind a UART receiver core. Each time the core finishes a character it presents one strobe carrying the byte plus a framing-error and a noise qualifier. The block stores the character, raises a data-available flag and drives a DMA request and an interrupt line. A CPU or a DMA engine then takes the byte out of the read-data port by pulsing a read strobe.

The same storage is used in two modes. With the FIFO-mode input low it is a single data register, so capacity is one and the single-register flag `rxne` is used. With FIFO mode high it is a queue of `FIFO_DEPTH` entries and the FIFO-not-empty flag `rxfne` is used. The DMA request follows whichever of these two flags belongs to the current mode. Each entry keeps its own error qualifiers. The sticky framing and noise flags are raised only when the character that carries them becomes the readable one. A character that finds the storage full is dropped and raises the sticky overrun flag. Interrupts are enabled separately for data-available and for errors.

Top module: `uart_rx_status`

## Requirements
- R1: After a synchronous active-low reset every output is 0: `rxne`, `rxfne`, `fe_flag`, `ore_flag`, `nf_flag`, `dma_req`, `irq` and `rd_data`.
- R2: With `fifo_en`=0, a received byte sets `rxne` at the next clock edge, `rd_data` shows that byte, and `rxfne` stays 0. A `rd_strobe` clears `rxne` at the next edge.
- R3: `dma_req` equals `rxne` when `fifo_en`=0 and `rxfne` when `fifo_en`=1. `rxne` and `rxfne` are never both 1.
- R4: With `fifo_en`=1, up to `FIFO_DEPTH` (default 8) bytes are held. They come out on `rd_data` in arrival order, one per `rd_strobe`.
- R5: A byte that arrives while the storage is full (capacity 1 with `fifo_en`=0, `FIFO_DEPTH` with `fifo_en`=1) and no read happens in that cycle is discarded. The stored data is unchanged and `ore_flag` is set. If a read happens in the same cycle, the byte is accepted.
- R6: `fe_flag` and `nf_flag` are set at the same clock edge at which the byte carrying that qualifier becomes the byte shown on `rd_data`. They are not set while that byte waits behind an earlier one.
- R7: Error flags stay set until their own clear strobe (`clr_fe`, `clr_ore`, `clr_nf`) is pulsed. Reading data does not clear them. If a set and a clear happen in the same cycle, the set wins.
- R8: `irq` = ((`rxne` or `rxfne`) and `rxne_ie`) or ((`fe_flag` or `ore_flag` or `nf_flag`) and `err_ie`).
- R9: A `rd_strobe` while the storage is empty has no effect on any flag or on `rd_data` (which reads 0 when empty).
- R10: Reset applied during operation empties the storage and clears every flag. The next received byte is the one shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects single-register mode |
| rxne_ie | input | 1 | Data-available interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| rx_valid | input | 1 | One-cycle strobe: a character was received |
| rx_data | input | 8 | Received character |
| rx_ferr | input | 1 | Framing-error qualifier of the character |
| rx_noise | input | 1 | Noise qualifier of the character |
| rd_strobe | input | 1 | Data read by CPU or DMA, pops the shown byte |
| clr_fe | input | 1 | Write-one-to-clear strobe for the framing flag |
| clr_ore | input | 1 | Write-one-to-clear strobe for the overrun flag |
| clr_nf | input | 1 | Write-one-to-clear strobe for the noise flag |
| rd_data | output | 8 | Byte at the head of storage, 0 when empty |
| rxne | output | 1 | Single-register data available (mode 0) |
| rxfne | output | 1 | Queue not empty (mode 1) |
| fe_flag | output | 1 | Sticky framing-error flag |
| ore_flag | output | 1 | Sticky overrun flag |
| nf_flag | output | 1 | Sticky noise flag |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Combined interrupt |

## Verification
A corrupted occupancy count or read pointer shows up at the ports on the very next read. Either `rd_data` no longer matches the byte the scoreboard expects, or the not-empty flag drops early or stays high after the last byte, and the bench compares these on every read. A wrong head-arrival event shows as an error flag one read too early or too late: it rises while its byte is still queued, or it fails to rise at the edge that makes the byte visible. Mishandled full detection shows within one cycle, as a missing `ore_flag` or as an altered byte at the head.

// File: rtl/uart_rx_status_pkg.sv
package uart_rx_status_pkg;

  localparam int RX_DATA_W = 8;

  typedef struct packed {
    logic [RX_DATA_W-1:0] data;
    logic                 ferr;
    logic                 noise;
  } rx_entry_t;

  function automatic logic irq_calc(input logic avail, input logic avail_ie,
                                    input logic any_err, input logic err_ie);
    return (avail & avail_ie) | (any_err & err_ie);
  endfunction

endpackage

// File: rtl/uart_rx_store.sv
module uart_rx_store
  import uart_rx_status_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      queue_mode,
  input  logic      push_req,
  input  rx_entry_t push_ent,
  input  logic      pop_req,
  output rx_entry_t head_ent,
  output logic      not_empty,
  output logic      drop_ev,
  output logic      head_load_ev,
  output rx_entry_t head_next
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  rx_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count, cap, after_pop;
  logic             pop_ev, push_ev;

  assign cap       = queue_mode ? CNT_W'(DEPTH) : CNT_W'(1);
  assign pop_ev    = pop_req && (count != '0);
  assign after_pop = count - CNT_W'(pop_ev);
  assign push_ev   = push_req && (after_pop < cap);
  assign drop_ev   = push_req && !push_ev;
  assign not_empty = (count != '0);
  assign head_ent  = not_empty ? mem[rd_ptr] : '0;

  always_comb begin
    head_load_ev = 1'b0;
    head_next    = push_ent;
    if (count == '0) begin
      head_load_ev = push_ev;
    end else if (pop_ev) begin
      if (count >= CNT_W'(2)) begin
        head_load_ev = 1'b1;
        head_next    = mem[ptr_inc(rd_ptr)];
      end else begin
        head_load_ev = push_ev;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (pop_ev)  rd_ptr <= ptr_inc(rd_ptr);
      if (push_ev) wr_ptr <= ptr_inc(wr_ptr);
      count <= after_pop + CNT_W'(push_ev);
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                mem[gi] <= '0;
      else if (push_ev && wr_ptr == PTR_W'(gi))  mem[gi] <= push_ent;
    end
  end

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && count >= cap) |=> (count == $past(count)));
  a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && pop_req && !push_req) |=> (count == '0));

endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_rx_status_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      head_load_ev,
  input  rx_entry_t head_next,
  input  logic      drop_ev,
  input  logic      clr_fe,
  input  logic      clr_ore,
  input  logic      clr_nf,
  output logic      fe_q,
  output logic      ore_q,
  output logic      nf_q
);

  logic fe_set, nf_set;
  assign fe_set = head_load_ev && head_next.ferr;
  assign nf_set = head_load_ev && head_next.noise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fe_q  <= 1'b0;
      ore_q <= 1'b0;
      nf_q  <= 1'b0;
    end else begin
      if (fe_set)       fe_q <= 1'b1;
      else if (clr_fe)  fe_q <= 1'b0;
      if (drop_ev)      ore_q <= 1'b1;
      else if (clr_ore) ore_q <= 1'b0;
      if (nf_set)       nf_q <= 1'b1;
      else if (clr_nf)  nf_q <= 1'b0;
    end
  end

  a_r5_ore_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> ore_q);
  a_r6_fe_with_head: assert property (@(posedge clk) disable iff (!rst_n)
    (head_load_ev && head_next.ferr) |=> fe_q);
  a_r7_fe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_q && !clr_fe) |=> fe_q);
  a_r7_nf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (nf_q && !clr_nf) |=> nf_q);

endmodule

// File: rtl/uart_rx_req.sv
module uart_rx_req
  import uart_rx_status_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic queue_mode,
  input  logic not_empty,
  input  logic fe_q,
  input  logic ore_q,
  input  logic nf_q,
  input  logic avail_ie,
  input  logic err_ie,
  output logic reg_full,
  output logic queue_ne,
  output logic dma_req,
  output logic irq
);

  logic any_err;
  assign any_err  = fe_q | ore_q | nf_q;
  assign reg_full = !queue_mode && not_empty;
  assign queue_ne = queue_mode && not_empty;
  assign dma_req  = queue_mode ? queue_ne : reg_full;
  assign irq      = irq_calc(reg_full | queue_ne, avail_ie, any_err, err_ie);

  a_r3_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_full && queue_ne));
  a_r8_err_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ie && any_err) |-> irq);

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_status_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fifo_en,
  input  logic                 rxne_ie,
  input  logic                 err_ie,
  input  logic                 rx_valid,
  input  logic [RX_DATA_W-1:0] rx_data,
  input  logic                 rx_ferr,
  input  logic                 rx_noise,
  input  logic                 rd_strobe,
  input  logic                 clr_fe,
  input  logic                 clr_ore,
  input  logic                 clr_nf,
  output logic [RX_DATA_W-1:0] rd_data,
  output logic                 rxne,
  output logic                 rxfne,
  output logic                 fe_flag,
  output logic                 ore_flag,
  output logic                 nf_flag,
  output logic                 dma_req,
  output logic                 irq
);

  rx_entry_t in_ent, head_ent, head_next;
  logic      not_empty, drop_ev, head_load_ev;

  assign in_ent = '{data: rx_data, ferr: rx_ferr, noise: rx_noise};

  uart_rx_store #(.DEPTH(FIFO_DEPTH)) store_i (
    .clk(clk), .rst_n(rst_n), .queue_mode(fifo_en),
    .push_req(rx_valid), .push_ent(in_ent), .pop_req(rd_strobe),
    .head_ent(head_ent), .not_empty(not_empty), .drop_ev(drop_ev),
    .head_load_ev(head_load_ev), .head_next(head_next)
  );

  uart_rx_flags flags_i (
    .clk(clk), .rst_n(rst_n), .head_load_ev(head_load_ev),
    .head_next(head_next), .drop_ev(drop_ev),
    .clr_fe(clr_fe), .clr_ore(clr_ore), .clr_nf(clr_nf),
    .fe_q(fe_flag), .ore_q(ore_flag), .nf_q(nf_flag)
  );

  uart_rx_req req_i (
    .clk(clk), .rst_n(rst_n), .queue_mode(fifo_en), .not_empty(not_empty),
    .fe_q(fe_flag), .ore_q(ore_flag), .nf_q(nf_flag),
    .avail_ie(rxne_ie), .err_ie(err_ie),
    .reg_full(rxne), .queue_ne(rxfne), .dma_req(dma_req), .irq(irq)
  );

  assign rd_data = head_ent.data;

  a_r3_dma_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (rxne || rxfne));
  a_r2_empty_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(rxne || rxfne) |-> (rd_data == '0));

endmodule

// File: tb/uart_rx_status_tb_top.sv
module uart_rx_status_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 0, rxne_ie = 0, err_ie = 0;
  logic       rx_valid = 0, rx_ferr = 0, rx_noise = 0, rd_strobe = 0;
  logic       clr_fe = 0, clr_ore = 0, clr_nf = 0;
  logic [7:0] rx_data = '0;
  logic [7:0] rd_data;
  logic       rxne, rxfne, fe_flag, ore_flag, nf_flag, dma_req, irq;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_q [$];

  always #4 clk = ~clk;

  uart_rx_status #(.FIFO_DEPTH(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rxne_ie(rxne_ie),
    .err_ie(err_ie), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ferr(rx_ferr), .rx_noise(rx_noise), .rd_strobe(rd_strobe),
    .clr_fe(clr_fe), .clr_ore(clr_ore), .clr_nf(clr_nf),
    .rd_data(rd_data), .rxne(rxne), .rxfne(rxfne), .fe_flag(fe_flag),
    .ore_flag(ore_flag), .nf_flag(nf_flag), .dma_req(dma_req), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver plus scoreboard: one cycle, inputs set at negedge, results seen at next negedge.
  task automatic step(input logic v, input logic [7:0] d, input logic fe,
                      input logic nf, input logic rd, input logic [2:0] clr);
    int sz = exp_q.size();
    int cap = fifo_en ? 8 : 1;
    int popd = (rd && sz > 0) ? 1 : 0;
    if (popd == 1) begin
      chk("R4 scoreboard read", rd_data, exp_q[0]);
      void'(exp_q.pop_front());
    end
    if (v && (sz - popd) < cap) exp_q.push_back(d);
    rx_valid = v; rx_data = d; rx_ferr = fe; rx_noise = nf; rd_strobe = rd;
    {clr_fe, clr_ore, clr_nf} = clr;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 0; rx_ferr = 0; rx_noise = 0; rd_strobe = 0;
    {clr_fe, clr_ore, clr_nf} = 3'b000;
  endtask

  task automatic summary_and_end();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    summary_and_end();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 flags", {rxne, rxfne, fe_flag, ore_flag, nf_flag, dma_req, irq}, 0);
    chk("R1 rd_data", rd_data, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 single register
    step(1, 8'hA5, 0, 0, 0, 0);
    chk("R2 rxne set", rxne, 1);
    chk("R2 rxfne idle", rxfne, 0);
    chk("R2 rd_data", rd_data, 8'hA5);
    chk("R3 dma follows rxne", dma_req, 1);
    // R5 full with simultaneous read: accepted
    step(1, 8'h5A, 0, 0, 1, 0);
    chk("R5 accept on read", rd_data, 8'h5A);
    chk("R5 no overrun", ore_flag, 0);
    // R5 overrun in single mode
    step(1, 8'h3C, 0, 0, 0, 0);
    chk("R5 ore set", ore_flag, 1);
    chk("R5 data kept", rd_data, 8'h5A);
    step(0, 0, 0, 0, 1, 0);
    chk("R2 rxne cleared", rxne, 0);
    chk("R3 dma dropped", dma_req, 0);
    chk("R7 read keeps ore", ore_flag, 1);
    step(0, 0, 0, 0, 0, 3'b010);
    chk("R7 ore cleared", ore_flag, 0);
    // R9 read when empty
    step(0, 0, 0, 0, 1, 0);
    chk("R9 empty read", {rxne, rxfne, fe_flag, ore_flag, nf_flag, dma_req}, 0);
    chk("R9 rd_data", rd_data, 0);

    // R4 queue mode
    fifo_en = 1;
    for (int i = 0; i < 8; i++)
      step(1, 8'(8'h11 * (i + 1)), (i == 2), (i == 4), 0, 0);
    chk("R3 rxfne source", {rxne, rxfne, dma_req}, 3'b011);
    chk("R6 no early flags", {fe_flag, nf_flag}, 0);
    step(1, 8'h99, 0, 0, 0, 0);
    chk("R5 queue overrun", ore_flag, 1);
    chk("R5 head kept", rd_data, 8'h11);
    step(0, 0, 0, 0, 1, 0);
    chk("R6 fe not yet", fe_flag, 0);
    err_ie = 1;
    step(0, 0, 0, 0, 1, 0);
    chk("R6 fe with head", fe_flag, 1);
    chk("R6 head byte", rd_data, 8'h33);
    step(0, 0, 0, 0, 1, 0);
    chk("R7 read keeps fe", fe_flag, 1);
    step(0, 0, 0, 0, 1, 3'b001);
    chk("R7 set beats clear", nf_flag, 1);
    chk("R8 err irq", irq, 1);
    step(0, 0, 0, 0, 0, 3'b111);
    chk("R7 all cleared", {fe_flag, ore_flag, nf_flag}, 0);
    chk("R8 irq off", irq, 0);
    rxne_ie = 1;
    @(negedge clk);
    chk("R8 data irq", irq, 1);
    while (exp_q.size() > 0) step(0, 0, 0, 0, 1, 0);
    chk("R4 drained", {rxfne, dma_req, irq}, 0);

    // R10 reset mid operation
    step(1, 8'h21, 1, 0, 0, 0);
    step(1, 8'h22, 0, 0, 0, 0);
    chk("R10 pre", {rxfne, fe_flag}, 2'b11);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    exp_q.delete();
    chk("R10 cleared", {rxne, rxfne, fe_flag, ore_flag, nf_flag, dma_req, irq}, 0);
    step(1, 8'h7E, 0, 0, 0, 0);
    chk("R10 fresh byte", rd_data, 8'h7E);
    step(0, 0, 0, 0, 1, 0);
    chk("R10 empty again", rxfne, 0);
    summary_and_end();
  end

endmodule